// File: doc/BRIEF.md
# Oscillator Fail Flag Controller

This block watches a slow timekeeping oscillator from the system clock domain and keeps a sticky flag that records any time the oscillator may have lost time. The flag is set when no oscillator edge is seen within a programmable number of system cycles, when the supply-low input is high, or when software halts the oscillator through a stop bit. Once set, it stays set until software writes it to zero. That write is accepted only after the oscillator has run without a break for a set number of seconds, counted from its own edges.

The block also drives a shared open-drain, active-low interrupt pin. If the fail interrupt, the alarm interrupt or the watchdog interrupt is enabled, the pin is pulled low while any enabled source is pending. If none of them is enabled, the pin acts as a plain output and follows a general-purpose level bit. Software reaches the block through a small synchronous register port. Reads have no side effects.

Top module: `osc_fail_ctrl`

## Requirements
- R1: After reset the fail flag reads 1, the control register reads stop=0, fail_ie=0, out_lvl=1 (value 3'b100), the timeout register reads 4, osc_halt_o is 0 and int_oe_o is 0.
- R2: If no rising oscillator edge reaches the system domain within the number of system cycles held in the timeout register (address 2), the oscillator counts as stopped and the fail flag is set. A running oscillator never sets it.
- R3: While low_supply_i is 1, the fail flag is set on the next clock edge.
- R4: Control bit 0 (stop) is mirrored on osc_halt_o. While it is 1, the fail flag is set.
- R5: The fail flag is cleared only by writing 0 to bit 0 of the flag register (address 1). Writing 1 there has no effect, and any other activity leaves a set flag at 1.
- R6: A clear write is ignored unless the oscillator has completed RUN_SECS seconds of OSC_PER_SEC rising edges each, with no stopped period and no stop bit in between. The run count saturates once it is reached.
- R7: Setting the stop bit and then returning it to 0 restarts the run count from zero, so a clear written soon after the restart is refused.
- R8: When a set cause and a clear write fall in the same cycle, the flag stays 1.
- R9: When fail_ie (control bit 1) and the fail flag are both 1, int_oe_o is 1 (pin pulled low). The pin is released when either of them is written to 0, unless another enabled source is pending.
- R10: A read (rd_en_i) returns the addressed register on rdata_o one cycle later and changes neither the fail flag nor int_oe_o.
- R11: With fail_ie, alarm_en_i and wdog_en_i all 0, int_oe_o equals the inverse of out_lvl (control bit 2). Otherwise int_oe_o is 1 exactly when some enabled source (fail flag, alarm_int_i or wdog_int_i) is pending. The block drives the pin only low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| osc_i | input | 1 | Timekeeping oscillator, asynchronous to clk_i |
| low_supply_i | input | 1 | Supply too low to sustain oscillation |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register address: 0 control, 1 flag, 2 timeout |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid one cycle after rd_en_i |
| alarm_en_i | input | 1 | Alarm interrupt enable from the alarm logic |
| alarm_int_i | input | 1 | Alarm interrupt pending |
| wdog_en_i | input | 1 | Watchdog interrupt enable |
| wdog_int_i | input | 1 | Watchdog interrupt pending |
| osc_halt_o | output | 1 | Holds the oscillator stopped while 1 |
| int_oe_o | output | 1 | Open-drain enable: 1 pulls the pin low, 0 leaves it released |

## Verification
The hardest state to reach from the ports is a clear write that arrives with the run count part-way through after a restart. The count is built from asynchronous oscillator edges passed through a synchroniser, so the bench uses a gated oscillator model whose period is several system cycles. Through the stop bit or the gate it halts and resumes that oscillator, then issues clear writes well inside and well past the run window. Both pin modes are swept over every combination of the six enable, pending and level inputs, once with the flag set and once with it cleared.

// File: rtl/osc_fail_pkg.sv
package osc_fail_pkg;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_FLAG = 2'd1,
    REG_TMO  = 2'd2,
    REG_RSVD = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic out_lvl;
    logic fail_ie;
    logic stop;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam logic [CTRL_W-1:0] CTRL_RST = 3'b100;

endpackage

// File: rtl/osc_stop_det.sv
module osc_stop_det #(
  parameter int SYNC_STAGES = 2,
  parameter int TMO_W       = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             osc_i,
  input  logic [TMO_W-1:0] timeout_i,
  output logic             rise_o,
  output logic             stopped_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [TMO_W-1:0]       gap_q;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[s] <= 1'b0;
        else         sync_q[s] <= osc_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[s] <= 1'b0;
        else         sync_q[s] <= sync_q[s-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign rise_o = sync_q[SYNC_STAGES-1] & ~prev_q;

  // cycles since last synchronised rising edge, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             gap_q <= '0;
    else if (rise_o)         gap_q <= '0;
    else if (gap_q != '1)    gap_q <= gap_q + 1'b1;
  end

  assign stopped_o = (gap_q >= timeout_i);

  a_r2_rise_not_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o && timeout_i != '0) |=> !stopped_o);

endmodule

// File: rtl/osc_run_timer.sv
module osc_run_timer #(
  parameter int OSC_PER_SEC = 32768,
  parameter int RUN_SECS    = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  output logic ok_o
);

  localparam int TW = $clog2(OSC_PER_SEC + 1);
  localparam int SW = $clog2(RUN_SECS + 1);
  localparam logic [TW-1:0] EDGE_LAST = TW'(OSC_PER_SEC - 1);
  localparam logic [SW-1:0] SECS_DONE = SW'(RUN_SECS);

  logic [TW-1:0] edge_q;
  logic [SW-1:0] secs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_q <= '0;
      secs_q <= '0;
    end else if (clr_i) begin
      edge_q <= '0;
      secs_q <= '0;
    end else if (tick_i && secs_q != SECS_DONE) begin
      if (edge_q == EDGE_LAST) begin
        edge_q <= '0;
        secs_q <= secs_q + 1'b1;
      end else begin
        edge_q <= edge_q + 1'b1;
      end
    end
  end

  assign ok_o = (secs_q == SECS_DONE);

  a_r6_secs_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    secs_q <= SECS_DONE);
  a_r7_clear_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !ok_o);
  a_r6_ok_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_o && !clr_i) |=> ok_o);

endmodule

// File: rtl/int_pin_mux.sv
module int_pin_mux (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fail_ie_i,
  input  logic fail_flag_i,
  input  logic alarm_en_i,
  input  logic alarm_int_i,
  input  logic wdog_en_i,
  input  logic wdog_int_i,
  input  logic out_lvl_i,
  output logic oe_o
);

  logic irq_mode;
  logic irq_pend;

  assign irq_mode = fail_ie_i | alarm_en_i | wdog_en_i;
  assign irq_pend = (fail_ie_i & fail_flag_i)
                  | (alarm_en_i & alarm_int_i)
                  | (wdog_en_i & wdog_int_i);
  // open drain: only a pull-low enable leaves the block
  assign oe_o = irq_mode ? irq_pend : ~out_lvl_i;

  a_r9_fail_pulls_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_ie_i && fail_flag_i) |-> oe_o);
  a_r11_out_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fail_ie_i && !alarm_en_i && !wdog_en_i && out_lvl_i) |-> !oe_o);
  a_r9_none_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_ie_i && !fail_flag_i && !(alarm_en_i && alarm_int_i)
     && !(wdog_en_i && wdog_int_i)) |-> !oe_o);

endmodule

// File: rtl/osc_fail_ctrl.sv
module osc_fail_ctrl
  import osc_fail_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int TMO_W       = 8,
  parameter int TMO_RST     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int OSC_PER_SEC = 32768,
  parameter int RUN_SECS    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              osc_i,
  input  logic              low_supply_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              alarm_en_i,
  input  logic              alarm_int_i,
  input  logic              wdog_en_i,
  input  logic              wdog_int_i,
  output logic              osc_halt_o,
  output logic              int_oe_o
);

  ctrl_t             ctrl_q;
  logic              flag_q;
  logic [TMO_W-1:0]  tmo_q;
  logic [DATA_W-1:0] rdata_q;
  logic              osc_rise;
  logic              osc_stopped;
  logic              run_ok;
  logic              wr_ctrl, wr_flag, wr_tmo;
  logic              set_evt, clr_req;

  assign wr_ctrl = wr_en_i && (reg_addr_e'(addr_i) == REG_CTRL);
  assign wr_flag = wr_en_i && (reg_addr_e'(addr_i) == REG_FLAG);
  assign wr_tmo  = wr_en_i && (reg_addr_e'(addr_i) == REG_TMO);

  osc_stop_det #(
    .SYNC_STAGES(SYNC_STAGES),
    .TMO_W      (TMO_W)
  ) u_det (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .osc_i    (osc_i),
    .timeout_i(tmo_q),
    .rise_o   (osc_rise),
    .stopped_o(osc_stopped)
  );

  osc_run_timer #(
    .OSC_PER_SEC(OSC_PER_SEC),
    .RUN_SECS   (RUN_SECS)
  ) u_run (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(osc_rise),
    .clr_i (osc_stopped | ctrl_q.stop),
    .ok_o  (run_ok)
  );

  int_pin_mux u_pin (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fail_ie_i  (ctrl_q.fail_ie),
    .fail_flag_i(flag_q),
    .alarm_en_i (alarm_en_i),
    .alarm_int_i(alarm_int_i),
    .wdog_en_i  (wdog_en_i),
    .wdog_int_i (wdog_int_i),
    .out_lvl_i  (ctrl_q.out_lvl),
    .oe_o       (int_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= ctrl_t'(CTRL_RST);
    else if (wr_ctrl) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tmo_q <= TMO_W'(TMO_RST);
    else if (wr_tmo) tmo_q <= wdata_i[TMO_W-1:0];
  end

  assign set_evt = osc_stopped | low_supply_i | ctrl_q.stop | (wr_ctrl & wdata_i[0]);
  assign clr_req = wr_flag & ~wdata_i[0];

  // set beats clear; clear needs a full run window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                flag_q <= 1'b1;
    else if (set_evt)           flag_q <= 1'b1;
    else if (clr_req && run_ok) flag_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (rd_en_i) begin
      unique case (reg_addr_e'(addr_i))
        REG_CTRL: rdata_q <= DATA_W'(ctrl_q);
        REG_FLAG: rdata_q <= DATA_W'(flag_q);
        REG_TMO:  rdata_q <= DATA_W'(tmo_q);
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign rdata_o    = rdata_q;
  assign osc_halt_o = ctrl_q.stop;

  a_r2_stopped_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_stopped |=> flag_q);
  a_r3_low_supply_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_supply_i |=> flag_q);
  a_r4_stop_bit_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.stop |=> flag_q);
  a_r5_only_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_req) |=> flag_q);
  a_r6_early_clear_refused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !run_ok) |=> flag_q);
  a_r10_read_keeps_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !wr_en_i && !set_evt) |=> $stable(flag_q));

endmodule

// File: tb/osc_fail_ctrl_test.sv
module osc_fail_ctrl_test;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          osc = 1'b0;
  logic          osc_en = 1'b1;
  logic          low_supply = 1'b0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [1:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          alarm_en = 1'b0, alarm_int = 1'b0, wdog_en = 1'b0, wdog_int = 1'b0;
  logic          osc_halt, int_oe;
  logic [1:0]    osc_div = '0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  osc_fail_ctrl #(
    .DATA_W(DW), .TMO_W(8), .TMO_RST(4), .SYNC_STAGES(2),
    .OSC_PER_SEC(4), .RUN_SECS(4)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .osc_i(osc), .low_supply_i(low_supply),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .alarm_en_i(alarm_en), .alarm_int_i(alarm_int),
    .wdog_en_i(wdog_en), .wdog_int_i(wdog_int), .osc_halt_o(osc_halt),
    .int_oe_o(int_oe)
  );

  always #10 clk = ~clk;

  // gated oscillator: half period 4 system cycles, stops while halted
  always @(negedge clk) begin
    if (osc_en && !osc_halt) begin
      osc_div <= osc_div + 2'd1;
      if (osc_div == 2'd3) osc <= ~osc;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = int'(rdata);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pin_sweep(input int flag, input string tag);
    for (int c = 0; c < 64; c++) begin
      logic fie, out, ae, ai, we, wi;
      int exp;
      {fie, out, ae, ai, we, wi} = 6'(c);
      alarm_en = ae; alarm_int = ai; wdog_en = we; wdog_int = wi;
      wr(2'd0, {5'b0, out, fie, 1'b0});
      if (fie || ae || we) exp = int'((fie && flag != 0) || (ae && ai) || (we && wi));
      else                 exp = int'(!out);
      check(tag, int'(int_oe), exp);
    end
    alarm_en = 0; alarm_int = 0; wdog_en = 0; wdog_int = 0;
    wr(2'd0, 8'h04);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int v;
    wait_cyc(3);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 int_oe", int'(int_oe), 0);
    check("R1 osc_halt", int'(osc_halt), 0);
    rd(2'd0, v); check("R1 ctrl", v, 4);
    rd(2'd1, v); check("R1 flag", v, 1);
    rd(2'd2, v); check("R1 timeout", v, 4);

    wr(2'd2, 8'd12);
    wait_cyc(40);
    wr(2'd1, 8'h00);
    rd(2'd1, v); check("R6 early clear refused", v, 1);
    wait_cyc(200);
    wr(2'd1, 8'h00);
    rd(2'd1, v); check("R6 clear after run window", v, 0);

    // R5 write of 1 has no effect; R2 running oscillator never sets
    wr(2'd1, 8'h01);
    rd(2'd1, v); check("R5 write one ignored", v, 0);
    wait_cyc(100);
    rd(2'd1, v); check("R2 running osc keeps flag clear", v, 0);

    pin_sweep(0, "R11 R9 sweep flag0");

    // R3 low supply sets
    @(negedge clk); low_supply = 1'b1;
    @(negedge clk); low_supply = 1'b0;
    rd(2'd1, v); check("R3 low supply sets flag", v, 1);
    wr(2'd1, 8'h00);
    rd(2'd1, v); check("R5 clear write accepted", v, 0);

    // R8 set wins over same-cycle clear
    @(negedge clk);
    low_supply = 1'b1; wr_en = 1'b1; addr = 2'd1; wdata = 8'h00;
    @(negedge clk);
    low_supply = 1'b0; wr_en = 1'b0;
    rd(2'd1, v); check("R8 set wins", v, 1);
    wr(2'd1, 8'h00);
    rd(2'd1, v); check("R8 later clear", v, 0);

    // R2 oscillator stop detection
    osc_en = 1'b0;
    wait_cyc(40);
    rd(2'd1, v); check("R2 stop detected", v, 1);
    osc_en = 1'b1;
    wait_cyc(40);
    wr(2'd1, 8'h00);
    rd(2'd1, v); check("R6 refused after resume", v, 1);
    wait_cyc(200);
    wr(2'd1, 8'h00);
    rd(2'd1, v); check("R6 accepted after resume", v, 0);

    // R4 stop bit, R7 restart
    wr(2'd0, 8'h05);
    check("R4 osc_halt follows stop", int'(osc_halt), 1);
    rd(2'd1, v); check("R4 stop bit sets flag", v, 1);
    wait_cyc(20);
    wr(2'd1, 8'h00);
    rd(2'd1, v); check("R4 clear refused while stopped", v, 1);
    wr(2'd0, 8'h04);
    check("R4 osc_halt released", int'(osc_halt), 0);
    wait_cyc(40);
    wr(2'd1, 8'h00);
    rd(2'd1, v); check("R7 run count restarted", v, 1);
    wait_cyc(200);
    wr(2'd1, 8'h00);
    rd(2'd1, v); check("R7 clear after full rerun", v, 0);

    // flag set again for sweep
    @(negedge clk); low_supply = 1'b1;
    @(negedge clk); low_supply = 1'b0;
    pin_sweep(1, "R11 R9 sweep flag1");

    // R9 and R10
    wr(2'd0, 8'h06);
    check("R9 fail irq pulls low", int'(int_oe), 1);
    for (int k = 0; k < 3; k++) begin
      rd(2'd1, v);
      check("R10 read returns flag", v, 1);
      check("R10 read keeps pin", int'(int_oe), 1);
    end
    rd(2'd0, v); check("R10 read ctrl", v, 6);
    wr(2'd0, 8'h04);
    check("R9 release by enable", int'(int_oe), 0);
    wr(2'd0, 8'h06);
    check("R9 re-enable pulls low", int'(int_oe), 1);
    wr(2'd1, 8'h00);
    check("R9 release by flag clear", int'(int_oe), 0);
    rd(2'd1, v); check("R10 read of clear flag", v, 0);
    check("R10 pin after read", int'(int_oe), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule